// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block moves a programmed number of data units from one memory region to another on behalf of software. Software loads a source address, a destination address, a unit count and a control word through a small register port. It then sets the channel enable bit. Once the global master enable is also on, the engine asks an arbiter for the bus. Each transfer unit is two accesses: a read at the source address and then a write of the same value to the destination address. Both accesses go through a simple request/acknowledge memory master port.

Two ownership policies are available. In cycle-stealing operation the engine drops its bus request after every unit and must win the bus again before the next unit. In burst operation it keeps the bus until the count is used up. The one exception is a level-sensitive external request that goes inactive: the engine then finishes the unit it has already started and gives the bus back early. A unit can be started by an internal automatic request or by an external request pin, and the pin can be sensed on either level or on either edge. Two interrupt lines report half-way progress and completion.

Top module: `xd_dma`

## Requirements
- R1: Register offsets are 0 source address, 1 destination address, 2 unit count, 3 control, 4 global (bit 0 = master enable). A read is requested with `reg_rd`, and the value appears on `reg_rdata` from the next clock edge. After reset every register reads 0, and `bus_req`, `mem_req`, `irq_half` and `irq_done` are low.
- R2: Control bits are: [0] channel enable; [1] done flag (read back; writing 0 clears it); [3:2] unit size (0 byte, 1 halfword, 2 word); [5:4] source address mode; [7:6] destination address mode; [8] burst; [9] external request; [11:10] request sense; [12] half interrupt enable; [13] done interrupt enable; [14] half flag (read only). Each unit reads the source and then writes the same value to the destination. The written value is zero-extended from the unit size, and `mem_size` carries the size code.
- R3: Address mode code 0 keeps the address fixed, code 1 adds the unit size in bytes after each access, and code 2 subtracts it.
- R4: In cycle-stealing mode (bit 8 = 0), `bus_req` falls after the write of every unit. Memory accesses are issued only while both `bus_req` and `bus_gnt` are high.
- R5: In burst mode, `bus_req` stays high from the first unit to the last, so a whole transfer needs a single grant.
- R6: In burst mode with a level-sensitive external request, if `dreq` is inactive when a unit's write completes, the bus is released and the remaining count is kept. The transfer resumes once `dreq` is active again.
- R7: Request sense codes are 0 low level, 1 high level, 2 rising edge and 3 falling edge. In an edge mode each detected edge allows one unit in cycle-stealing operation. In a level mode units run only while the level is active.
- R8: With automatic request (bit 9 = 0), a transfer starts only when the channel enable and the master enable are both 1 and the done flag is 0.
- R9: After the last unit the count reads 0, the done flag is set and the engine stops. A programmed count of 0 means 2^CNT_W units.
- R10: `irq_half` is high while bit 12 is set and ceil(N/2) of N programmed units have completed. `irq_done` is high while bit 13 and the done flag are set. A control write with bits 0 and 1 at 0 clears both.
- R11: While the channel is enabled or a unit is in flight, writes to the address and count registers are ignored, and so are control writes, except one with bit 0 = 0. Such a write clears the enable, and the engine stops once the current unit has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | RA_W | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | DW | Write data, zero-extended |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |
| dreq | input | 1 | External transfer request |
| irq_half | output | 1 | Half-way interrupt |
| irq_done | output | 1 | Completion interrupt |

## Verification
The bench builds the engine with 32-bit addresses and data and a 4-bit count (CNT_W = 4). With that count width, a programmed zero means 16 units, and the wrap case runs to completion in a few hundred cycles. The narrow count also keeps the half-way threshold small, so the ceiling rule for odd counts is easy to observe. The bench memory can insert wait states every other cycle, which exercises the rule that a request and its address are held until the acknowledge arrives.

// File: rtl/xd_pkg.sv
package xd_pkg;
  localparam int RG_SRC   = 0;
  localparam int RG_DST   = 1;
  localparam int RG_CNT   = 2;
  localparam int RG_CTRL  = 3;
  localparam int RG_GLB   = 4;
  localparam int CTRL_MSB = 13;

  typedef enum logic [1:0] {UNIT_B = 2'd0, UNIT_H = 2'd1, UNIT_W = 2'd2} unit_e;
  typedef enum logic [1:0] {AM_FIX = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2} amode_e;
  typedef enum logic [1:0] {SNS_LOW = 2'd0, SNS_HIGH = 2'd1, SNS_RISE = 2'd2, SNS_FALL = 2'd3} sense_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR} st_e;

  // control bits [13:2]
  typedef struct packed {
    logic   done_ie;
    logic   half_ie;
    sense_e sense;
    logic   ext_req;
    logic   burst;
    amode_e dmode;
    amode_e smode;
    unit_e  unit;
  } ctrl_t;
endpackage

// File: rtl/xd_regs.sv
module xd_regs import xd_pkg::*; #(
  parameter int RA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [CTRL_MSB:0] wr_bits,
  input  logic              busy,
  output logic              ld_src,
  output logic              ld_dst,
  output logic              ld_cnt,
  output logic              clr_flags,
  output logic              chan_en,
  output logic              master_en,
  output ctrl_t             ctrl
);
  logic idle, hit_ctrl;

  assign idle      = !chan_en && !busy;
  assign hit_ctrl  = wr_en && (wr_addr == RA_W'(RG_CTRL));
  assign ld_src    = wr_en && (wr_addr == RA_W'(RG_SRC)) && idle;
  assign ld_dst    = wr_en && (wr_addr == RA_W'(RG_DST)) && idle;
  assign ld_cnt    = wr_en && (wr_addr == RA_W'(RG_CNT)) && idle;
  assign clr_flags = hit_ctrl && !wr_bits[1] && (!chan_en || !wr_bits[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      chan_en   <= 1'b0;
      master_en <= 1'b0;
    end else begin
      if (hit_ctrl) begin
        if (idle) begin
          ctrl    <= ctrl_t'(wr_bits[CTRL_MSB:2]);
          chan_en <= wr_bits[0];
        end else if (!wr_bits[0]) begin
          chan_en <= 1'b0;   // stop request: honoured at the unit boundary
        end
      end
      if (wr_en && (wr_addr == RA_W'(RG_GLB)))
        master_en <= wr_bits[0];
    end
  end
endmodule

// File: rtl/xd_req.sv
module xd_req import xd_pkg::*; (
  input  logic   clk,
  input  logic   rst,
  input  logic   dreq,
  input  logic   ext_req,
  input  sense_e sense,
  input  logic   take,
  output logic   req_ok,
  output logic   level_mode
);
  logic dreq_q, edge_pend, lvl_act, edge_hit;

  assign lvl_act  = (sense == SNS_HIGH) ? dreq : !dreq;
  assign edge_hit = (sense == SNS_RISE) ? (dreq && !dreq_q) : (!dreq && dreq_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq_q    <= 1'b0;
      edge_pend <= 1'b0;
    end else begin
      dreq_q <= dreq;
      if (ext_req && sense[1] && edge_hit) edge_pend <= 1'b1;
      else if (take || !ext_req)           edge_pend <= 1'b0;
    end
  end

  assign req_ok     = !ext_req || (sense[1] ? edge_pend : lvl_act);
  assign level_mode = ext_req && !sense[1];
endmodule

// File: rtl/xd_chan.sv
module xd_chan import xd_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_src,
  input  logic             ld_dst,
  input  logic             ld_cnt,
  input  logic [AW-1:0]    ld_addr,
  input  logic [CNT_W-1:0] ld_count,
  input  logic             clr_flags,
  input  unit_e            unit,
  input  amode_e           smode,
  input  amode_e           dmode,
  input  logic             burst,
  input  logic             chan_en,
  input  logic             master_en,
  input  logic             req_ok,
  input  logic             level_mode,
  input  logic             bus_gnt,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             bus_req,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             take,
  output logic [AW-1:0]    src_q,
  output logic [AW-1:0]    dst_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             te,
  output logic             half_f
);
  st_e              st;
  logic [CNT_W-1:0] half_pt, cnt_nx;
  logic [DW-1:0]    rd_m;
  logic             go, keep, last;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input amode_e m, input unit_e u);
    logic [AW-1:0] d;
    d = (u == UNIT_B) ? AW'(1) : (u == UNIT_H) ? AW'(2) : AW'(4);
    case (m)
      AM_INC:  step = a + d;
      AM_DEC:  step = a - d;
      default: step = a;
    endcase
  endfunction

  always_comb begin
    case (unit)
      UNIT_B:  rd_m = DW'(mem_rdata[7:0]);
      UNIT_H:  rd_m = DW'(mem_rdata[15:0]);
      default: rd_m = mem_rdata;
    endcase
  end

  assign go     = chan_en && master_en && !te && req_ok;
  assign take   = (st == ST_IDLE) && go;
  assign cnt_nx = cnt_q - 1'b1;
  assign last   = (cnt_nx == '0);
  assign keep   = burst && chan_en && master_en && !(level_mode && !req_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      half_pt <= '0;
      mem_wdata <= '0;
      te      <= 1'b0;
      half_f  <= 1'b0;
    end else begin
      if (ld_src) src_q <= ld_addr;
      if (ld_dst) dst_q <= ld_addr;
      if (ld_cnt) begin
        cnt_q   <= ld_count;
        half_pt <= {ld_count == '0, ld_count[CNT_W-1:1]};
      end
      if (clr_flags) begin
        te     <= 1'b0;
        half_f <= 1'b0;
      end
      case (st)
        ST_IDLE: if (go) st <= ST_ARB;
        ST_ARB:  if (bus_gnt) st <= ST_RD;
        ST_RD: if (mem_ack) begin
          mem_wdata <= rd_m;
          src_q     <= step(src_q, smode, unit);
          st        <= ST_WR;
        end
        ST_WR: if (mem_ack) begin
          dst_q <= step(dst_q, dmode, unit);
          cnt_q <= cnt_nx;
          if (cnt_nx == half_pt) half_f <= 1'b1;
          if (last) te <= 1'b1;
          st <= (!last && keep) ? ST_RD : ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_req  = (st != ST_IDLE);
  assign mem_req  = (st == ST_RD) || (st == ST_WR);
  assign mem_we   = (st == ST_WR);
  assign mem_addr = (st == ST_WR) ? dst_q : src_q;
endmodule

// File: rtl/xd_dma.sv
module xd_dma import xd_pkg::*; #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 24,
  parameter int RA_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  input  logic            dreq,
  output logic            irq_half,
  output logic            irq_done
);
  localparam int STAT_W = CTRL_MSB + 2;

  ctrl_t            ctrl;
  logic             ld_src, ld_dst, ld_cnt, clr_flags, chan_en, master_en;
  logic             req_ok, level_mode, take, te, half_f;
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    rd_mux;

  xd_regs #(.RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_bits(reg_wdata[CTRL_MSB:0]), .busy(bus_req),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .clr_flags(clr_flags),
    .chan_en(chan_en), .master_en(master_en), .ctrl(ctrl)
  );

  xd_req u_req (
    .clk(clk), .rst(rst), .dreq(dreq), .ext_req(ctrl.ext_req), .sense(ctrl.sense),
    .take(take), .req_ok(req_ok), .level_mode(level_mode)
  );

  xd_chan #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_chan (
    .clk(clk), .rst(rst), .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt),
    .ld_addr(reg_wdata[AW-1:0]), .ld_count(reg_wdata[CNT_W-1:0]), .clr_flags(clr_flags),
    .unit(ctrl.unit), .smode(ctrl.smode), .dmode(ctrl.dmode), .burst(ctrl.burst),
    .chan_en(chan_en), .master_en(master_en), .req_ok(req_ok), .level_mode(level_mode),
    .bus_gnt(bus_gnt), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .take(take), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt),
    .te(te), .half_f(half_f)
  );

  assign mem_size = ctrl.unit;

  always_comb begin
    case (reg_addr)
      RA_W'(RG_SRC):  rd_mux = DW'(src_q);
      RA_W'(RG_DST):  rd_mux = DW'(dst_q);
      RA_W'(RG_CNT):  rd_mux = DW'(cnt);
      RA_W'(RG_CTRL): rd_mux = DW'({half_f, ctrl, te, chan_en});
      RA_W'(RG_GLB):  rd_mux = DW'(master_en);
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_half  <= 1'b0;
      irq_done  <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq_half <= ctrl.half_ie && half_f;
      irq_done <= ctrl.done_ie && te;
    end
  end

  if (STAT_W > DW) begin : g_bad_width
    initial $error("data width too small for control readback");
  end
endmodule

// File: rtl/xd_dma_chk.sv
module xd_dma_chk #(
  parameter int AW    = 32,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [AW-1:0]    mem_addr,
  input logic             burst,
  input logic             te,
  input logic [CNT_W-1:0] cnt
);
  assert_access_owned_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (bus_req && bus_gnt));

  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  assert_steal_release_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack && !burst) |=> !bus_req);

  assert_done_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(te) |-> (cnt == '0));
endmodule

bind xd_dma xd_dma_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .burst(ctrl.burst),
  .te(te), .cnt(cnt)
);

// File: tb/xd_dma_tb.sv
module xd_dma_tb;
  localparam int AW = 32, DW = 32, CNT_W = 4, RA_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic reg_wr = 0, reg_rd = 0, bus_gnt = 0, dreq = 0, slow = 0, tick = 0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata, mem_wdata, mem_rdata;
  logic bus_req, mem_req, mem_we, mem_ack, irq_half, irq_done;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;

  function automatic logic [31:0] pattern(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'h5A5A_0F0F;
  endfunction

  assign mem_rdata = pattern(mem_addr);
  assign mem_ack   = mem_req && (!slow || tick);
  always @(posedge clk) begin
    bus_gnt <= bus_req;
    tick    <= ~tick;
  end

  xd_dma #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .RA_W(RA_W)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .dreq(dreq),
    .irq_half(irq_half), .irq_done(irq_done)
  );

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_rd = 0, grabs = 0, half_at = -1;
  logic prev_breq = 0, prev_half = 0;
  string cur_tag = "R2";
  logic [66:0] exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: predicted access sequence, compared on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && mem_ack) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL %s unexpected access actual=%h expected=none", cur_tag, mem_addr);
        end else begin
          logic [66:0] e;
          e = exp_q.pop_front();
          chk({cur_tag, " addr"}, mem_addr, e[63:32]);
          chk({cur_tag, " kind/size"}, {29'd0, mem_we, mem_size}, {29'd0, e[66:64]});
          if (mem_we) chk({cur_tag, " data"}, mem_wdata, e[31:0]);
        end
        if (mem_we) n_wr++; else n_rd++;
      end
      if (bus_req && !prev_breq) grabs++;
      if (irq_half && !prev_half) half_at = n_wr;
      prev_breq = bus_req;
      prev_half = irq_half;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = RA_W'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_rd = 1; reg_addr = RA_W'(a);
    @(posedge clk); #1;
    reg_rd = 0;
    v = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input int en, u, sm, dm, bu, ex, sn, hi, di);
    return 32'(en | (u << 2) | (sm << 4) | (dm << 6) | (bu << 8) | (ex << 9) |
               (sn << 10) | (hi << 12) | (di << 13));
  endfunction

  function automatic logic [31:0] nstep(input logic [31:0] a, input int m, input logic [31:0] b);
    return (m == 1) ? a + b : (m == 2) ? a - b : a;
  endfunction

  task automatic plan(input logic [31:0] s, input logic [31:0] d, input int n, input int u, input int sm, input int dm);
    logic [31:0] b, m;
    b = (u == 0) ? 1 : (u == 1) ? 2 : 4;
    m = (u == 0) ? 32'hFF : (u == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b0, 2'(u), s, 32'h0});
      exp_q.push_back({1'b1, 2'(u), d, pattern(s) & m});
      s = nstep(s, sm, b);
      d = nstep(d, dm, b);
    end
  endtask

  task automatic prog(input logic [31:0] s, input logic [31:0] d, input int n);
    wr(0, s); wr(1, d); wr(2, n);
    n_wr = 0; n_rd = 0; grabs = 0; half_at = -1;
  endtask

  task automatic wait_done(input string t);
    int k;
    k = 0;
    while (!irq_done && k < 3000) begin @(negedge clk); k++; end
    chk({t, " done irq"}, 32'(irq_done), 32'd1);
  endtask

  task automatic disarm();
    wr(3, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int left;
    repeat (4) @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irqs", {30'd0, irq_half, irq_done}, 0);
    rd(3, v); chk("R1 ctrl read", v, 0);
    rd(2, v); chk("R1 count read", v, 0);
    wr(4, 1);
    rd(4, v); chk("R1 master read", v, 1);

    // R4 cycle stealing, word, inc/inc, wait states
    cur_tag = "R4"; slow = 1;
    prog(32'h100, 32'h200, 4);
    plan(32'h100, 32'h200, 4, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 0, 0, 0, 0, 1));
    wait_done("R4");
    chk("R4 grabs per unit", grabs, 4);
    chk("R2 queue drained", exp_q.size(), 0);
    rd(2, v); chk("R9 count zero", v, 0);
    rd(3, v); chk("R9 done flag", {31'd0, v[1]}, 1);
    chk("R10 done irq high", 32'(irq_done), 1);
    disarm();
    chk("R10 done irq cleared", 32'(irq_done), 0);
    slow = 0;

    // R5 burst, byte, src decrement, dst increment
    cur_tag = "R3";
    prog(32'h50, 32'h300, 5);
    plan(32'h50, 32'h300, 5, 0, 2, 1);
    wr(3, mk(1, 0, 2, 1, 1, 0, 0, 0, 1));
    wait_done("R5");
    chk("R5 single grant", grabs, 1);
    chk("R3 queue drained", exp_q.size(), 0);
    disarm();

    // R10 half irq with odd count, halfword fixed addresses
    cur_tag = "R3 fixed";
    prog(32'h40, 32'h80, 3);
    plan(32'h40, 32'h80, 3, 1, 0, 0);
    wr(3, mk(1, 1, 0, 0, 0, 0, 0, 1, 1));
    wait_done("R10");
    chk("R10 half irq after ceil(3/2)", half_at, 2);
    chk("R3 fixed drained", exp_q.size(), 0);
    rd(3, v); chk("R10 half flag", {31'd0, v[14]}, 1);
    disarm();
    chk("R10 half irq cleared", 32'(irq_half), 0);

    // R8 master enable gates auto request
    cur_tag = "R8";
    wr(4, 0);
    prog(32'h400, 32'h500, 2);
    plan(32'h400, 32'h500, 2, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 0, 0, 0, 0, 1));
    repeat (20) @(negedge clk);
    chk("R8 no grab without master", grabs, 0);
    wr(4, 1);
    wait_done("R8");
    chk("R8 units after master on", n_wr, 2);
    repeat (5) @(negedge clk);
    chk("R8 done flag blocks restart", n_wr, 2);
    disarm();

    // R11 writes ignored while enabled
    cur_tag = "R11"; slow = 1;
    prog(32'h600, 32'h700, 6);
    plan(32'h600, 32'h700, 6, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 0, 0, 0, 0, 1));
    wr(3, mk(1, 0, 0, 0, 0, 0, 0, 0, 1));
    wr(0, 32'hFFF0);
    wait_done("R11");
    chk("R11 queue drained", exp_q.size(), 0);
    rd(3, v); chk("R11 unit field kept", {30'd0, v[3:2]}, 2);
    disarm(); slow = 0;

    // R11 clearing enable stops at a unit boundary
    cur_tag = "R11 stop";
    prog(32'h800, 32'h900, 10);
    plan(32'h800, 32'h900, 10, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 0, 0, 0, 0, 1));
    while (n_wr < 3) @(negedge clk);
    wr(3, 0);
    repeat (20) @(negedge clk);
    left = 10 - n_wr;
    chk("R11 whole units only", n_rd, n_wr);
    chk("R11 bus released", 32'(bus_req), 0);
    chk("R11 stopped early", 32'(n_wr < 10), 1);
    rd(2, v); chk("R11 count kept", v, left);
    chk("R11 untouched accesses", exp_q.size(), 2 * left);
    exp_q.delete();

    // R6 burst with level request dropping
    cur_tag = "R6"; dreq = 1;
    prog(32'hA00, 32'hB00, 6);
    plan(32'hA00, 32'hB00, 6, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 1, 1, 1, 0, 1));
    while (n_wr < 2) @(negedge clk);
    dreq = 0;
    repeat (20) @(negedge clk);
    left = 6 - n_wr;
    chk("R6 bus released early", 32'(bus_req), 0);
    chk("R6 not finished", 32'(left > 0), 1);
    rd(2, v); chk("R6 count kept", v, left);
    dreq = 1;
    wait_done("R6");
    chk("R6 second grant", grabs, 2);
    chk("R6 drained", exp_q.size(), 0);
    disarm(); dreq = 0;

    // R7 rising edge, one unit per edge
    cur_tag = "R7 rise";
    prog(32'hC00, 32'hD00, 3);
    plan(32'hC00, 32'hD00, 3, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 0, 1, 2, 0, 1));
    repeat (10) @(negedge clk);
    chk("R7 idle without edge", n_wr, 0);
    for (int p = 1; p <= 2; p++) begin
      @(posedge clk); #1 dreq = 1;
      @(posedge clk); #1 dreq = 0;
      repeat (15) @(negedge clk);
      chk("R7 one unit per edge", n_wr, p);
    end
    rd(3, v); chk("R7 not done yet", {31'd0, v[1]}, 0);
    @(posedge clk); #1 dreq = 1;
    @(posedge clk); #1 dreq = 0;
    wait_done("R7 rise");
    disarm();

    // R7 low level
    cur_tag = "R7 low"; dreq = 1;
    prog(32'hE00, 32'hF00, 2);
    plan(32'hE00, 32'hF00, 2, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 0, 1, 0, 0, 1));
    repeat (10) @(negedge clk);
    chk("R7 low inactive", n_wr, 0);
    dreq = 0;
    wait_done("R7 low");
    disarm();

    // R7 falling edge
    cur_tag = "R7 fall"; dreq = 1;
    prog(32'h1000, 32'h1100, 1);
    plan(32'h1000, 32'h1100, 1, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 0, 1, 3, 0, 1));
    repeat (10) @(negedge clk);
    chk("R7 fall waits", n_wr, 0);
    @(posedge clk); #1 dreq = 0;
    wait_done("R7 fall");
    disarm(); dreq = 0;

    // R9 programmed zero means 2^CNT_W units
    cur_tag = "R9";
    prog(32'h2000, 32'h3000, 0);
    plan(32'h2000, 32'h3000, 16, 2, 1, 1);
    wr(3, mk(1, 2, 1, 1, 1, 0, 0, 0, 1));
    wait_done("R9");
    chk("R9 full wrap units", n_wr, 16);
    chk("R9 drained", exp_q.size(), 0);
    disarm();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule